// File: doc/BRIEF.md
# Indirect Codec Register Access Bridge

This block lets a host reach a small bank of 8-bit codec control registers through two 32-bit words instead of a flat address map. The command word, at byte offset 0x0, holds a 7-bit register index, 8 bits of write data and a write-request flag that doubles as a busy indicator. The data word, at byte offset 0x4, returns the contents of the register the command word points at, together with an interrupt flag.

The bridge owns the register bank and its reset values. To write a register, the host sets the request flag along with the index and data. The flag then reads back as busy until the internal write completes, which is a fixed number of cycles later. To read a register, the host writes the command word with the request flag clear. This changes only the index. The data word follows the newly addressed register after a fixed pipeline latency. One status register carries two ramp-done flags. Hardware sets these flags through dedicated inputs, and the host clears them by writing zero to the flag bit.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset the command word reads 0x00000000. Six cycles after reset is released, the data word bits 7:0 show 0x0c, the reset value of register 0.
- R2: A host write to offset 0x0 with bit 16 set, accepted while not busy, makes command word bit 16 read 1 for exactly 4 cycles starting the cycle after the write. It then reads 0.
- R3: When that busy period ends, command word bits 7:0 have been stored into the register selected by bits 14:8. A later read returns them.
- R4: After a command-word write changes the index, the data word bits 7:0 keep the old register's value for 5 cycles. They show the new register's value from the 6th cycle on.
- R5: A command-word write with bit 16 clear updates only the index field. It does not set busy and does not modify any register.
- R6: A command-word write made while busy is ignored. The pending write, index and data fields are unaffected.
- R7: The 28 registers at indices 0..27 reset to 0c aa 78 00 00 ff 03 51 3f 00 00 04 04 04 04 04 04 0a 0a 00 00 00 c0 34 07 44 1f 00, in index order.
- R8: Indices 20 and 21 always read 0x00, and writes to them are ignored.
- R9: Indices 28..127 read 0x00, and writes to them are ignored.
- R10: In register 9, bit 3 is set by `ramp_up_set` and bit 2 by `ramp_down_set`. A host write clears a flag only where the written bit is 0, and a set pulse wins over a clear in the same cycle. The other bits of register 9 are plain read/write.
- R11: Data word bit 8 is the OR of register 9 bits 3 and 2. It follows them without the read latency.
- R12: Reads at byte offsets other than 0x0 and 0x4 return zero. Host writes to any offset other than 0x0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 4 | Host byte offset (0x0 command word, 0x4 data word) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Word at host_addr, combinational |
| ramp_up_set | input | 1 | Hardware pulse setting the ramp-up-done flag |
| ramp_down_set | input | 1 | Hardware pulse setting the ramp-down-done flag |

## Verification
The assertions watch several behaviours on every cycle:
- the exact length of each busy period;
- that the index stays frozen while a write is pending;
- that an index-only update never raises busy;
- that a flag set pulse always shows on the interrupt bit next cycle;
- that the test and out-of-range indices always read zero at the bank output.

Only the bench scenarios can show the rest. These are the reset contents of all 28 registers, the cycle at which the data word switches after an index change, and the value a write actually commits. They also cover the write-zero-to-clear behaviour of the status flags, and that a strobe issued during busy leaves the target register untouched.

// File: rtl/codec_bridge_pkg.sv
package codec_bridge_pkg;

    localparam int NUM_REGS   = 28;
    localparam int IDX_W      = 7;
    localparam int BYTE_W     = 8;
    localparam int WR_CYCLES  = 4;
    localparam int RD_STAGES  = 6;
    localparam int STATUS_IDX = 9;
    localparam int UP_BIT     = 3;
    localparam int DN_BIT     = 2;
    localparam int TEST_IDX_A = 20;
    localparam int TEST_IDX_B = 21;

    // host word layout; positions are decoded by software
    localparam int REQ_BIT    = 16;
    localparam int IDX_LSB    = 8;
    localparam int IRQ_BIT    = 8;
    localparam logic [3:0] CMD_OFF  = 4'h0;
    localparam logic [3:0] DATA_OFF = 4'h4;

    function automatic logic [BYTE_W-1:0] power_on_value(input int idx);
        logic [BYTE_W-1:0] v;
        case (idx)
            0:        v = 8'h0c;
            1:        v = 8'haa;
            2:        v = 8'h78;
            5:        v = 8'hff;
            6:        v = 8'h03;
            7:        v = 8'h51;
            8:        v = 8'h3f;
            11, 12, 13, 14, 15, 16: v = 8'h04;
            17, 18:   v = 8'h0a;
            22:       v = 8'hc0;
            23:       v = 8'h34;
            24:       v = 8'h07;
            25:       v = 8'h44;
            26:       v = 8'h1f;
            default:  v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic bit idx_backed(input int idx, input int nregs);
        return (idx < nregs) && (idx != TEST_IDX_A) && (idx != TEST_IDX_B);
    endfunction

endpackage

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
    import codec_bridge_pkg::*;
#(
    parameter int LAT   = WR_CYCLES,
    parameter int AW    = IDX_W,
    parameter int DW    = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [31:0]   cmd_wdata,
    output logic          busy_o,
    output logic [AW-1:0] idx_o,
    output logic [DW-1:0] wval_o,
    output logic          commit_o
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [AW-1:0] idx;
        logic [DW-1:0] wval;
    } seq_t;

    seq_t seq_d, seq_q;
    logic commit_d;

    always_comb begin
        seq_d    = seq_q;
        commit_d = 1'b0;
        if (seq_q.busy) begin
            if (seq_q.cnt == '0) begin
                seq_d.busy = 1'b0;
                commit_d   = 1'b1;
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end else if (cmd_we) begin
            seq_d.idx = cmd_wdata[IDX_LSB +: AW];
            if (cmd_wdata[REQ_BIT]) begin
                seq_d.busy = 1'b1;
                seq_d.cnt  = CW'(LAT - 1);
                seq_d.wval = cmd_wdata[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o   = seq_q.busy;
    assign idx_o    = seq_q.idx;
    assign wval_o   = seq_q.wval;
    assign commit_o = commit_d;

endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
    import codec_bridge_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    parameter int AW    = IDX_W,
    parameter int DW    = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_val,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_val,
    input  logic          up_set,
    input  logic          dn_set,
    output logic          irq_o
);
    logic [NREGS-1:0][DW-1:0] bank_vec;

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        if (!idx_backed(i, NREGS)) begin : g_absent
            assign bank_vec[i] = '0;
        end else begin : g_present
            logic [DW-1:0] val_d, val_q;
            logic          hit;
            assign hit = wr_en && (wr_idx == AW'(i));

            if (i == STATUS_IDX) begin : g_status
                always_comb begin
                    val_d = val_q;
                    if (hit) begin
                        val_d = wr_val;
                        val_d[UP_BIT] = val_q[UP_BIT] & wr_val[UP_BIT];
                        val_d[DN_BIT] = val_q[DN_BIT] & wr_val[DN_BIT];
                    end
                    if (up_set) val_d[UP_BIT] = 1'b1;
                    if (dn_set) val_d[DN_BIT] = 1'b1;
                end
            end else begin : g_plain
                always_comb begin
                    val_d = val_q;
                    if (hit) val_d = wr_val;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) val_q <= DW'(power_on_value(i));
                else        val_q <= val_d;
            end
            assign bank_vec[i] = val_q;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NREGS; k++) begin
            if (rd_idx == AW'(k)) rd_val = bank_vec[k];
        end
    end

    assign irq_o = bank_vec[STATUS_IDX][UP_BIT] | bank_vec[STATUS_IDX][DN_BIT];

endmodule

// File: rtl/read_delay_line.sv
module read_delay_line
    import codec_bridge_pkg::*;
#(
    parameter int STAGES = RD_STAGES,
    parameter int DW     = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [STAGES-1:0][DW-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
    import codec_bridge_pkg::*;
#(
    parameter int NREGS  = NUM_REGS,
    parameter int WR_LAT = WR_CYCLES,
    parameter int RD_LAT = RD_STAGES
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [3:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        ramp_up_set,
    input  logic        ramp_down_set
);
    logic              cmd_we;
    logic              busy;
    logic [IDX_W-1:0]  cmd_idx;
    logic [BYTE_W-1:0] cmd_wval;
    logic              commit;
    logic [BYTE_W-1:0] bank_rd;
    logic [BYTE_W-1:0] rd_delayed;
    logic              irq;

    assign cmd_we = host_we && (host_addr == CMD_OFF);

    cmd_sequencer #(.LAT(WR_LAT), .AW(IDX_W), .DW(BYTE_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_wdata(host_wdata),
        .busy_o   (busy),
        .idx_o    (cmd_idx),
        .wval_o   (cmd_wval),
        .commit_o (commit)
    );

    codec_reg_bank #(.NREGS(NREGS), .AW(IDX_W), .DW(BYTE_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (commit),
        .wr_idx (cmd_idx),
        .wr_val (cmd_wval),
        .rd_idx (cmd_idx),
        .rd_val (bank_rd),
        .up_set (ramp_up_set),
        .dn_set (ramp_down_set),
        .irq_o  (irq)
    );

    read_delay_line #(.STAGES(RD_LAT), .DW(BYTE_W)) u_rd (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (bank_rd),
        .dout (rd_delayed)
    );

    always_comb begin
        host_rdata = '0;
        if (host_addr == CMD_OFF) begin
            host_rdata[REQ_BIT]               = busy;
            host_rdata[IDX_LSB +: IDX_W]      = cmd_idx;
            host_rdata[BYTE_W-1:0]            = cmd_wval;
        end else if (host_addr == DATA_OFF) begin
            host_rdata[IRQ_BIT]               = irq;
            host_rdata[BYTE_W-1:0]            = rd_delayed;
        end
    end

endmodule

// File: rtl/codec_reg_bridge_chk.sv
module codec_reg_bridge_chk
    import codec_bridge_pkg::*;
#(
    parameter int WR_LAT = WR_CYCLES,
    parameter int NREGS  = NUM_REGS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              cmd_we,
    input logic [31:0]       host_wdata,
    input logic [IDX_W-1:0]  cmd_idx,
    input logic              ramp_up_set,
    input logic              ramp_down_set,
    input logic              irq,
    input logic [BYTE_W-1:0] bank_rd
);
    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 8'(WR_LAT))); // R2
    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we) |=> $stable(cmd_idx)); // R6
    AST_INDEX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy && !host_wdata[REQ_BIT]) |=> !busy); // R5
    AST_UP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_up_set |=> irq); // R10
    AST_DN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_down_set |=> irq); // R11
    AST_TEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_idx == IDX_W'(TEST_IDX_A)) || (cmd_idx == IDX_W'(TEST_IDX_B))) |-> (bank_rd == '0)); // R8
    AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cmd_idx) >= NREGS) |-> (bank_rd == '0)); // R9

endmodule

bind codec_reg_bridge codec_reg_bridge_chk #(.WR_LAT(WR_LAT), .NREGS(NREGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .cmd_we       (cmd_we),
    .host_wdata   (host_wdata),
    .cmd_idx      (cmd_idx),
    .ramp_up_set  (ramp_up_set),
    .ramp_down_set(ramp_down_set),
    .irq          (irq),
    .bank_rd      (bank_rd)
);

// File: tb/codec_reg_bridge_bench.sv
module codec_reg_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = 4'h0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        ramp_up_set = 1'b0;
    logic        ramp_down_set = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    codec_reg_bridge u_codec_reg_bridge (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ramp_up_set(ramp_up_set), .ramp_down_set(ramp_down_set)
    );

    localparam logic [7:0] DEFS [28] = '{
        8'h0c, 8'haa, 8'h78, 8'h00, 8'h00, 8'hff, 8'h03, 8'h51,
        8'h3f, 8'h00, 8'h00, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04,
        8'h04, 8'h0a, 8'h0a, 8'h00, 8'h00, 8'h00, 8'hc0, 8'h34,
        8'h07, 8'h44, 8'h1f, 8'h00 };

    typedef struct packed {
        logic [6:0] idx;
        logic [7:0] wval;
        logic [7:0] expv;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{7'd1,   8'h5a, 8'h5a},
        '{7'd27,  8'h80, 8'h80},
        '{7'd20,  8'hff, 8'h00},
        '{7'd21,  8'h12, 8'h00},
        '{7'd30,  8'h11, 8'h00},
        '{7'd127, 8'h77, 8'h00},
        '{7'd9,   8'hff, 8'hf3},
        '{7'd0,   8'h00, 8'h00} };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic host_wr(input logic [3:0] off, input logic [31:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = off; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd_word(input logic [3:0] off, output logic [31:0] v);
        host_addr = off;
        #1;
        v = host_rdata;
    endtask

    function automatic logic [31:0] cmd(input logic req, input logic [6:0] idx, input logic [7:0] val);
        return {15'b0, req, 1'b0, idx, val};
    endfunction

    task automatic reg_write(input logic [6:0] idx, input logic [7:0] val);
        host_wr(4'h0, cmd(1'b1, idx, val));
        repeat (4) @(negedge clk);
    endtask

    task automatic reg_read(input logic [6:0] idx, output logic [7:0] v);
        logic [31:0] w;
        host_wr(4'h0, cmd(1'b0, idx, 8'h00));
        repeat (6) @(negedge clk);
        rd_word(4'h4, w);
        v = w[7:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_word(4'h0, w);
        check("R1 command word after reset", w, 32'h0);
        repeat (6) @(negedge clk);
        rd_word(4'h4, w);
        check("R1 data word shows register 0", w, 32'h0000000c);

        // R7 all reset values; R8 test slots read zero
        for (int i = 0; i < 28; i++) begin
            reg_read(7'(i), b);
            check((i == 20 || i == 21) ? "R8 test slot reads zero" : "R7 reset value",
                  {24'b0, b}, (i == 20 || i == 21) ? 32'h0 : {24'b0, DEFS[i]});
        end

        // R4 latency: index 27 (0x00) -> index 7 (0x51)
        host_wr(4'h0, cmd(1'b0, 7'd7, 8'h00));
        repeat (5) @(negedge clk);
        rd_word(4'h4, w);
        check("R4 old value held for 5 cycles", {24'b0, w[7:0]}, 32'h00);
        @(negedge clk);
        rd_word(4'h4, w);
        check("R4 new value at cycle 6", {24'b0, w[7:0]}, 32'h51);

        // R2 busy window
        host_wr(4'h0, cmd(1'b1, 7'd2, 8'h33));
        rd_word(4'h0, w);
        check("R2 busy right after strobe", {31'b0, w[16]}, 32'h1);
        repeat (3) @(negedge clk);
        rd_word(4'h0, w);
        check("R2 busy in 4th cycle", {31'b0, w[16]}, 32'h1);
        @(negedge clk);
        rd_word(4'h0, w);
        check("R2 busy clear in 5th cycle", {31'b0, w[16]}, 32'h0);
        reg_read(7'd2, b);
        check("R3 written value read back", {24'b0, b}, 32'h33);

        // R5 index-only update leaves register and busy alone
        host_wr(4'h0, cmd(1'b0, 7'd8, 8'h99));
        rd_word(4'h0, w);
        check("R5 no busy on index update", w, cmd(1'b0, 7'd8, 8'h33));
        repeat (6) @(negedge clk);
        rd_word(4'h4, w);
        check("R5 register 8 unchanged", {24'b0, w[7:0]}, 32'h3f);

        // R6 strobe during busy ignored
        host_wr(4'h0, cmd(1'b1, 7'd3, 8'h11));
        host_wr(4'h0, cmd(1'b1, 7'd4, 8'h22));
        repeat (3) @(negedge clk);
        rd_word(4'h0, w);
        check("R6 fields kept from first strobe", w, cmd(1'b0, 7'd3, 8'h11));
        reg_read(7'd4, b);
        check("R6 second target untouched", {24'b0, b}, 32'h00);
        reg_read(7'd3, b);
        check("R6 first write landed", {24'b0, b}, 32'h11);

        // vector table: R3 plain writes, R8 test slots, R9 out of range, R10 flag bits
        foreach (VECS[k]) begin
            reg_write(VECS[k].idx, VECS[k].wval);
            reg_read(VECS[k].idx, b);
            check("R3/R8/R9/R10 vector readback", {24'b0, b}, {24'b0, VECS[k].expv});
        end

        // R10 / R11 flags (register 9 now 0xf3)
        @(negedge clk); ramp_up_set = 1'b1;
        @(negedge clk); ramp_up_set = 1'b0;
        rd_word(4'h4, w);
        check("R11 irq after ramp-up set", {31'b0, w[8]}, 32'h1);
        reg_read(7'd9, b);
        check("R10 ramp-up flag visible", {24'b0, b}, 32'hfb);
        reg_write(7'd9, 8'hfb);
        reg_read(7'd9, b);
        check("R10 writing one keeps flag", {24'b0, b}, 32'hfb);
        reg_write(7'd9, 8'hf3);
        reg_read(7'd9, b);
        check("R10 writing zero clears flag", {24'b0, b}, 32'hf3);
        rd_word(4'h4, w);
        check("R11 irq low after clear", {31'b0, w[8]}, 32'h0);
        @(negedge clk); ramp_down_set = 1'b1;
        @(negedge clk); ramp_down_set = 1'b0;
        rd_word(4'h4, w);
        check("R11 irq after ramp-down set", {31'b0, w[8]}, 32'h1);
        reg_read(7'd9, b);
        check("R10 ramp-down flag visible", {24'b0, b}, 32'hf7);
        reg_write(7'd9, 8'h00);
        rd_word(4'h4, w);
        check("R11 irq low after full clear", {31'b0, w[8]}, 32'h0);

        // R12 other offsets
        rd_word(4'h8, w);
        check("R12 unmapped offset reads zero", w, 32'h0);
        host_wr(4'h4, 32'hffffffff);
        host_wr(4'h8, 32'hffffffff);
        rd_word(4'h0, w);
        check("R12 writes elsewhere ignored", w, cmd(1'b0, 7'd9, 8'h00));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule